// File: doc/BRIEF.md
# Ternary-Configured Two-Phase Logic Cell

This block is a cycle-level model of a fine-grain reconfigurable logic cell. It takes two data bits and gives one result bit. Three control inputs choose which two-input Boolean function the cell computes, and each control input carries one of three levels. The cell is built as two cascaded dynamic stages. The first stage forms an intermediate node from the two data bits. The second stage then passes that node through, inverts it, or leaves the output at its precharged value.

Four phase strobes sequence one computation: precharge-1, evaluate-1, precharge-2, evaluate-2. Each strobe acts on the rising clock edge at which it is high. The result shows on the output after the edge that carries the evaluate-2 strobe, and it stays there until the next precharge-2. The controls may take a new value before each new sequence, so successive sequences can compute different functions. A control combination that does not name a function drives the output low and raises an invalid flag.

Top module: `trilevel_logic_cell`

## Requirements
- R1: Each control is 2 bits wide, with plus = 2'b01, zero = 2'b00 and minus = 2'b11. The code 2'b10 on any control is illegal. If any control holds 2'b10 at evaluate-2, then after that edge y_out = 0 and cfg_bad = 1.
- R2: The controls are written (ctl_a, ctl_b, ctl_c), and y_out after evaluate-2 is as follows:
  - (+,+,+) gives NOR and (+,+,-) gives OR.
  - (-,-,+) gives AND and (-,-,-) gives NAND.
  - (+,0,+) gives NOT A and (+,0,-) gives A.
  - (0,+,+) gives NOT B and (0,+,-) gives B.
  - (+,-,+) gives B AND NOT A and (+,-,-) gives A OR NOT B.
  - (-,+,+) gives A AND NOT B and (-,+,-) gives B OR NOT A.
  - (0,0,0) gives constant 1 and (0,0,-) gives constant 0.
  - For each of these, cfg_bad = 0.
- R3: A precharge-1 edge clears the intermediate node. If evaluate-1 is then skipped and a follow configuration such as (+,0,-) is evaluated, y_out = 0.
- R4: The intermediate node takes the data inputs at the evaluate-1 edge and keeps them until the next precharge-1. Changes to a_in and b_in after evaluate-1 do not change the result of the following evaluate-2.
- R5: After a precharge-2 edge, y_out = 1 and cfg_bad = 0.
- R6: On an edge with no strobe high, y_out and cfg_bad keep their values, whatever the data and control inputs do.
- R7: Any of the 13 ternary combinations not listed in R2 makes y_out = 0 and cfg_bad = 1 after evaluate-2. A later precharge-2 clears the flag.
- R8: While reset is active, and after it is released, y_out = 1 and cfg_bad = 0.
- R9: The function is taken from the controls of each sequence on its own, so back-to-back sequences with different controls each give their own function's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; strobes act on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 1 | Data input A |
| b_in | input | 1 | Data input B |
| ctl_a | input | 2 | First ternary control level |
| ctl_b | input | 2 | Second ternary control level |
| ctl_c | input | 2 | Third ternary control level (second stage mode) |
| ph_pre1 | input | 1 | Precharge strobe of the first stage |
| ph_eval1 | input | 1 | Evaluate strobe of the first stage |
| ph_pre2 | input | 1 | Precharge strobe of the second stage |
| ph_eval2 | input | 1 | Evaluate strobe of the second stage |
| y_out | output | 1 | Cell result |
| cfg_bad | output | 1 | Invalid configuration flag |

## Verification
The bench runs all 64 raw control codes against all four data pairs. This catches a decode that swaps the two implication functions, treats a zero third control as valid outside the all-zero case, or takes the illegal code 2'b10 for a level. Dedicated sequences skip evaluate-1 and change the data between evaluate-1 and evaluate-2. A design without a cleared node would then return a stale 1, and a design that reads the data at evaluate-2 would follow the late inputs. Idle edges with moving inputs expose an output that does not hold its value. An invalid sequence followed by a valid one shows whether the flag is left stuck high.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_ZERO  = 2'b00,
        LVL_PLUS  = 2'b01,
        LVL_BAD   = 2'b10,
        LVL_MINUS = 2'b11
    } lvl_e;

    // first-stage node function
    typedef enum logic [2:0] {
        S1_OR,
        S1_NAND,
        S1_PASS_A,
        S1_PASS_B,
        S1_A_OR_NB,
        S1_NA_OR_B,
        S1_ZERO
    } s1_op_e;

    // second-stage behaviour at evaluate
    typedef enum logic [1:0] {
        S2_INVERT,
        S2_FOLLOW,
        S2_KEEP,
        S2_KILL
    } s2_mode_e;

    typedef struct packed {
        logic node;
    } s1_state_t;

    typedef struct packed {
        logic y;
        logic bad;
    } s2_state_t;
endpackage

// File: rtl/tlc_ctl_decode.sv
module tlc_ctl_decode
    import tlc_pkg::*;
(
    input  logic [LVL_W-1:0] ctl_a,
    input  logic [LVL_W-1:0] ctl_b,
    input  logic [LVL_W-1:0] ctl_c,
    output s1_op_e           s1_op,
    output s2_mode_e         s2_mode
);
    lvl_e la, lb, lc;
    logic pair_ok;
    logic zero_pair;

    assign la = lvl_e'(ctl_a);
    assign lb = lvl_e'(ctl_b);
    assign lc = lvl_e'(ctl_c);

    // the first two levels pick the node function
    always_comb begin
        pair_ok   = 1'b1;
        zero_pair = 1'b0;
        s1_op     = S1_ZERO;
        case ({la, lb})
            {LVL_PLUS,  LVL_PLUS }: s1_op = S1_OR;
            {LVL_MINUS, LVL_MINUS}: s1_op = S1_NAND;
            {LVL_PLUS,  LVL_ZERO }: s1_op = S1_PASS_A;
            {LVL_ZERO,  LVL_PLUS }: s1_op = S1_PASS_B;
            {LVL_PLUS,  LVL_MINUS}: s1_op = S1_A_OR_NB;
            {LVL_MINUS, LVL_PLUS }: s1_op = S1_NA_OR_B;
            {LVL_ZERO,  LVL_ZERO }: begin
                s1_op     = S1_ZERO;
                zero_pair = 1'b1;
            end
            default: pair_ok = 1'b0;
        endcase
    end

    // the third level picks the output stage mode
    always_comb begin
        s2_mode = S2_KILL;
        if (pair_ok) begin
            case (lc)
                LVL_PLUS:  s2_mode = zero_pair ? S2_KILL : S2_INVERT;
                LVL_MINUS: s2_mode = S2_FOLLOW;
                LVL_ZERO:  s2_mode = zero_pair ? S2_KEEP : S2_KILL;
                default:   s2_mode = S2_KILL;
            endcase
        end
    end
endmodule

// File: rtl/tlc_stage1.sv
module tlc_stage1
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pre,
    input  logic   eval,
    input  logic   a,
    input  logic   b,
    input  s1_op_e op,
    output logic   node
);
    s1_state_t st_d, st_q;
    logic      f_val;

    always_comb begin
        case (op)
            S1_OR:      f_val = a | b;
            S1_NAND:    f_val = ~(a & b);
            S1_PASS_A:  f_val = a;
            S1_PASS_B:  f_val = b;
            S1_A_OR_NB: f_val = a | ~b;
            S1_NA_OR_B: f_val = ~a | b;
            default:    f_val = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (pre) begin
            st_d.node = 1'b0;
        end else if (eval) begin
            st_d.node = f_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign node = st_q.node;
endmodule

// File: rtl/tlc_stage2.sv
module tlc_stage2
    import tlc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pre,
    input  logic     eval,
    input  logic     node,
    input  s2_mode_e mode,
    output logic     y,
    output logic     bad
);
    s2_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pre) begin
            st_d.y   = 1'b1;
            st_d.bad = 1'b0;
        end else if (eval) begin
            case (mode)
                S2_INVERT: begin st_d.y = ~node; st_d.bad = 1'b0; end
                S2_FOLLOW: begin st_d.y = node;  st_d.bad = 1'b0; end
                S2_KEEP:   begin st_d.y = 1'b1;  st_d.bad = 1'b0; end
                default:   begin st_d.y = 1'b0;  st_d.bad = 1'b1; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{y: 1'b1, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign y   = st_q.y;
    assign bad = st_q.bad;
endmodule

// File: rtl/trilevel_logic_cell.sv
module trilevel_logic_cell
    import tlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    input  logic [LVL_W-1:0] ctl_a,
    input  logic [LVL_W-1:0] ctl_b,
    input  logic [LVL_W-1:0] ctl_c,
    input  logic             ph_pre1,
    input  logic             ph_eval1,
    input  logic             ph_pre2,
    input  logic             ph_eval2,
    output logic             y_out,
    output logic             cfg_bad
);
    s1_op_e   s1_op;
    s2_mode_e s2_mode;
    logic     node;

    tlc_ctl_decode u_dec (
        .ctl_a   (ctl_a),
        .ctl_b   (ctl_b),
        .ctl_c   (ctl_c),
        .s1_op   (s1_op),
        .s2_mode (s2_mode)
    );

    tlc_stage1 u_s1 (
        .clk  (clk),
        .rst_n(rst_n),
        .pre  (ph_pre1),
        .eval (ph_eval1),
        .a    (a_in),
        .b    (b_in),
        .op   (s1_op),
        .node (node)
    );

    tlc_stage2 u_s2 (
        .clk  (clk),
        .rst_n(rst_n),
        .pre  (ph_pre2),
        .eval (ph_eval2),
        .node (node),
        .mode (s2_mode),
        .y    (y_out),
        .bad  (cfg_bad)
    );
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ctl_a,
    input logic [1:0] ctl_b,
    input logic [1:0] ctl_c,
    input logic       ph_pre1,
    input logic       ph_eval1,
    input logic       ph_pre2,
    input logic       ph_eval2,
    input logic       y_out,
    input logic       cfg_bad
);
    logic any_strobe;
    assign any_strobe = ph_pre1 | ph_eval1 | ph_pre2 | ph_eval2;

    assert_pre2_sets_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ph_pre2 |=> (y_out && !cfg_bad));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> ($stable(y_out) && $stable(cfg_bad)));

    assert_bad_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> !y_out);

    assert_bad_only_at_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_bad) |-> $past(ph_eval2));

    assert_illegal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_eval2 && !ph_pre2 && (ctl_a == 2'b10 || ctl_b == 2'b10 || ctl_c == 2'b10))
        |=> (cfg_bad && !y_out));

    assert_const_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_eval2 && ctl_a == 2'b00 && ctl_b == 2'b00 && ctl_c == 2'b00)
        |=> (y_out && !cfg_bad));
endmodule

bind trilevel_logic_cell tlc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b),
    .ctl_c   (ctl_c),
    .ph_pre1 (ph_pre1),
    .ph_eval1(ph_eval1),
    .ph_pre2 (ph_pre2),
    .ph_eval2(ph_eval2),
    .y_out   (y_out),
    .cfg_bad (cfg_bad)
);

// File: tb/trilevel_logic_cell_test.sv
`timescale 1ns/1ps
module trilevel_logic_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_in = 1'b0, b_in = 1'b0;
    logic [1:0] ctl_a = 2'b00, ctl_b = 2'b00, ctl_c = 2'b00;
    logic       ph_pre1 = 1'b0, ph_eval1 = 1'b0, ph_pre2 = 1'b0, ph_eval2 = 1'b0;
    logic       y_out, cfg_bad;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    localparam logic [1:0] P = 2'b01, Z = 2'b00, M = 2'b11;

    always #10 clk = ~clk;

    trilevel_logic_cell uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c),
        .ph_pre1(ph_pre1), .ph_eval1(ph_eval1), .ph_pre2(ph_pre2), .ph_eval2(ph_eval2),
        .y_out(y_out), .cfg_bad(cfg_bad)
    );

    task automatic check(input string tag, input logic act_y, input logic act_bad,
                         input logic exp_y, input logic exp_bad);
        checks++;
        if (act_y !== exp_y || act_bad !== exp_bad) begin
            errors++;
            $display("FAIL %s: y=%b bad=%b expected y=%b bad=%b", tag, act_y, act_bad, exp_y, exp_bad);
        end
    endtask

    // requirement table of R2; everything else is invalid (R1/R7)
    task automatic ref_model(input logic [1:0] ca, cb, cc, input logic a, b,
                             output logic ey, output logic ebad);
        ebad = 1'b0;
        case ({ca, cb, cc})
            {P,P,P}: ey = ~(a | b);
            {P,P,M}: ey = a | b;
            {P,Z,P}: ey = ~a;
            {P,Z,M}: ey = a;
            {M,M,P}: ey = a & b;
            {M,M,M}: ey = ~(a & b);
            {P,M,P}: ey = b & ~a;
            {P,M,M}: ey = a | ~b;
            {Z,P,P}: ey = ~b;
            {Z,P,M}: ey = b;
            {Z,Z,Z}: ey = 1'b1;
            {Z,Z,M}: ey = 1'b0;
            {M,P,P}: ey = a & ~b;
            {M,P,M}: ey = ~a | b;
            default: begin ey = 1'b0; ebad = 1'b1; end
        endcase
    endtask

    // one-clock strobe: 0=pre1 1=eval1 2=pre2 3=eval2 4=none
    task automatic strobe(input int which);
        @(negedge clk);
        ph_pre1  = (which == 0);
        ph_eval1 = (which == 1);
        ph_pre2  = (which == 2);
        ph_eval2 = (which == 3);
        @(negedge clk);
        ph_pre1 = 1'b0; ph_eval1 = 1'b0; ph_pre2 = 1'b0; ph_eval2 = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] ca, cb, cc, input logic a, b);
        @(negedge clk);
        ctl_a = ca; ctl_b = cb; ctl_c = cc; a_in = a; b_in = b;
    endtask

    task automatic full_cycle(input logic [1:0] ca, cb, cc, input logic a, b, input string tag);
        logic ey, eb;
        set_cfg(ca, cb, cc, a, b);
        strobe(0);
        strobe(1);
        strobe(2);
        check("R5 precharge-2 sets y", y_out, cfg_bad, 1'b1, 1'b0);
        strobe(3);
        ref_model(ca, cb, cc, a, b, ey, eb);
        check(tag, y_out, cfg_bad, ey, eb);
    endtask

    task automatic t_reset;
        check("R8 reset state", y_out, cfg_bad, 1'b1, 1'b0);
    endtask

    task automatic t_exhaustive;
        for (int code = 0; code < 64; code++) begin
            for (int ab = 0; ab < 4; ab++) begin
                logic [1:0] ca, cb, cc;
                string tag;
                ca = code[5:4]; cb = code[3:2]; cc = code[1:0];
                if (ca == 2'b10 || cb == 2'b10 || cc == 2'b10) tag = "R1 illegal code";
                else tag = "R2/R7 function table";
                full_cycle(ca, cb, cc, ab[1], ab[0], tag);
            end
        end
    endtask

    task automatic t_hold;
        full_cycle(P, P, M, 1'b0, 1'b0, "R2 OR of zeros");
        for (int i = 0; i < 3; i++) begin
            set_cfg(P, P, P, i[0], ~i[0]);
            strobe(4);
            check("R6 hold low", y_out, cfg_bad, 1'b0, 1'b0);
        end
        full_cycle(Z, M, P, 1'b1, 1'b1, "R7 invalid");
        set_cfg(P, Z, M, 1'b1, 1'b0);
        strobe(4);
        strobe(4);
        check("R6 hold invalid flag", y_out, cfg_bad, 1'b0, 1'b1);
    endtask

    task automatic t_capture;
        set_cfg(P, Z, M, 1'b1, 1'b0);
        strobe(0);
        strobe(1);
        set_cfg(P, Z, M, 1'b0, 1'b1);
        strobe(2);
        strobe(3);
        check("R4 node captured at evaluate-1", y_out, cfg_bad, 1'b1, 1'b0);
    endtask

    task automatic t_pre1_clear;
        full_cycle(P, Z, M, 1'b1, 1'b0, "R2 pass A");
        strobe(0);
        strobe(2);
        strobe(3);
        check("R3 precharge-1 clears node", y_out, cfg_bad, 1'b0, 1'b0);
    endtask

    task automatic t_reconfig;
        full_cycle(P, P, P, 1'b1, 1'b0, "R9 NOR then");
        check("R9 NOR result", y_out, cfg_bad, 1'b0, 1'b0);
        full_cycle(M, M, M, 1'b1, 1'b0, "R9 NAND next");
        check("R9 NAND result", y_out, cfg_bad, 1'b1, 1'b0);
    endtask

    task automatic t_flag_clear;
        full_cycle(M, Z, M, 1'b0, 1'b0, "R7 invalid pair");
        check("R7 flag raised", y_out, cfg_bad, 1'b0, 1'b1);
        set_cfg(Z, Z, Z, 1'b0, 1'b0);
        strobe(2);
        check("R7 flag cleared by precharge-2", y_out, cfg_bad, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exhaustive();
        t_hold();
        t_capture();
        t_pre1_clear();
        t_reconfig();
        t_flag_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule